// File: doc/BRIEF.md
# Sequential Break Condition Unit

This unit watches a processor's data bus and instruction stream and raises a break request when programmed hardware conditions are met. It holds four condition channels. Each channel compares either the data-access address on the bus or the program counter of the instruction being executed against a programmed value under a bit mask. A match can further be narrowed by an address-space ID, by access direction, and, on channel 1 only, by the value and width of the transferred data. A program-counter channel can stop before the matched instruction runs or after it has run.

The channels feed a sequencer. In independent mode any channel that matches requests a break at once. In a chained mode the request is raised only when the channels involved have matched in strictly descending order, ending with channel 1. The unit is configured through static level inputs. A one-cycle reconfigure strobe must accompany every change of that configuration and returns the sequencer to its starting point.

Top module: `seq_break_unit`

## Requirements
- R1: With `seq_mode_i` = 0 (independent mode), `brk_o` is high in the same cycle in which any enabled channel reports a match event.
- R2: A channel whose bit in `ch_en_i` is low never contributes an event, whatever the bus or instruction stimulus.
- R3: A channel with its `ch_pc_i` bit low matches only when `bus_valid_i` is high and `bus_addr_i` equals its address in every bit set in its mask. A channel with its `ch_pc_i` bit high matches only when `exec_valid_i` is high and `pc_i` equals its address under the same mask; it ignores bus accesses.
- R4: The 2-bit direction field of a bus channel is encoded 0 = either direction, 1 = reads only (`bus_wr_i` low), 2 = writes only (`bus_wr_i` high), 3 = either direction.
- R5: When a channel's ASID enable bit is set, it matches only when `asid_i` equals its 8-bit programmed ID. When the bit is clear, the ID is ignored.
- R6: With `dat_en_i` high, channel 1 (bit 0 of the channel vectors) also requires `bus_size_i` to equal `dat_size_i` (0 = byte, 1 = word, 2 = longword) and the low 8, 16 or 32 bits of `bus_data_i` to equal `dat_val_i`. No other channel compares data.
- R7: A program-counter channel with its `ch_after_i` bit set does not report in the cycle of the match. It reports on the next later cycle with `exec_valid_i` high, which is the instruction that follows.
- R8: A before-execution program-counter match on an instruction flagged by `exec_slot_i` (a delay slot) cannot stop ahead of it. It is reported on the next later `exec_valid_i` cycle, the branch target. Without `exec_slot_i` a before-execution match reports in its own cycle.
- R9: `seq_mode_i` values 1, 2 and 3 select the chains 2→1, 3→2→1 and 4→3→2→1. `brk_o` rises only in the cycle in which channel 1 matches after every higher channel of the chain has matched in descending order. Channels outside the chain have no effect.
- R10: In a chained mode, a match from any channel other than the one the chain awaits next neither advances nor restarts the chain.
- R11: After a chained break the chain restarts, so a further match of channel 1 alone raises no request.
- R12: A cycle with `cfg_wr_i` high raises no request, discards pending after-execution and delay-slot reports, and restarts the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Reconfigure strobe |
| seq_mode_i | input | 2 | 0 independent, 1..3 chain length minus one |
| ch_en_i | input | 4 | Channel enables, bit i = channel i+1 |
| ch_pc_i | input | 4 | 1 = compare program counter, 0 = compare bus address |
| ch_after_i | input | 4 | 1 = report after the matched instruction |
| ch_addr_i | input | 128 | Compare address per channel, 32 bits each |
| ch_mask_i | input | 128 | Address compare mask per channel, 1 = bit compared |
| ch_dir_i | input | 8 | Direction field per channel, 2 bits each |
| ch_asid_en_i | input | 4 | ASID qualifier enable per channel |
| ch_asid_i | input | 32 | ASID per channel, 8 bits each |
| dat_en_i | input | 1 | Enable data compare on channel 1 |
| dat_val_i | input | 32 | Data compare value |
| dat_size_i | input | 2 | Data compare width |
| bus_valid_i | input | 1 | Data access present on bus |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | 32 | Access address |
| bus_data_i | input | 32 | Access data, right aligned |
| bus_size_i | input | 2 | Access width |
| asid_i | input | 8 | Current address-space ID |
| exec_valid_i | input | 1 | An instruction executes this cycle |
| exec_slot_i | input | 1 | That instruction sits in a delay slot |
| pc_i | input | 32 | Program counter of that instruction |
| brk_o | output | 1 | Break request |

## Verification
Two functions can land in one cycle: the reconfigure strobe, and the final match of a chain or a pending deferred report coming due. The bench provokes this by raising `cfg_wr_i` in the cycle in which channel 1 completes a 2→1 chain. Random stimulus also raises the strobe at a low rate while bus and instruction matches continue. In both cases the strobe must win: `brk_o` stays low in that cycle, and the next lone channel-1 match must also leave it low, which shows that the chain restarted rather than completed.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    DIR_EITHER = 2'd0,
    DIR_READ   = 2'd1,
    DIR_WRITE  = 2'd2,
    DIR_BOTH   = 2'd3
  } brk_dir_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } brk_size_e;
endpackage

// File: rtl/brk_chan.sv
module brk_chan import brk_pkg::*; #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ASW      = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic           pc_src_i,
  input  logic           after_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  mask_i,
  input  logic [1:0]     dir_i,
  input  logic           asid_en_i,
  input  logic [ASW-1:0] asid_cfg_i,
  input  logic           dat_en_i,
  input  logic [DW-1:0]  dat_val_i,
  input  logic [1:0]     dat_size_i,
  input  logic           bus_valid_i,
  input  logic           bus_wr_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]  bus_data_i,
  input  logic [1:0]     bus_size_i,
  input  logic [ASW-1:0] asid_i,
  input  logic           exec_valid_i,
  input  logic           exec_slot_i,
  input  logic [AW-1:0]  pc_i,
  output logic           ev_o
);
  logic asid_ok, bus_addr_ok, pc_ok, dir_ok, data_ok;
  logic bus_hit, pc_hit, pc_now, defer_set, defer_fire;
  logic defer_q;

  assign asid_ok     = !asid_en_i || (asid_i == asid_cfg_i);
  assign bus_addr_ok = ((bus_addr_i ^ addr_i) & mask_i) == '0;
  assign pc_ok       = ((pc_i ^ addr_i) & mask_i) == '0;

  always_comb begin
    unique case (brk_dir_e'(dir_i))
      DIR_READ:  dir_ok = !bus_wr_i;
      DIR_WRITE: dir_ok = bus_wr_i;
      default:   dir_ok = 1'b1;
    endcase
  end

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0] dmask;
      always_comb begin
        unique case (brk_size_e'(dat_size_i))
          SZ_BYTE: dmask = DW'(8'hFF);
          SZ_WORD: dmask = DW'(16'hFFFF);
          default: dmask = '1;
        endcase
      end
      assign data_ok = !dat_en_i ||
                       ((bus_size_i == dat_size_i) && (((bus_data_i ^ dat_val_i) & dmask) == '0));
    end else begin : g_nodata
      logic unused_dat;
      assign unused_dat = ^{dat_en_i, dat_val_i, dat_size_i, bus_data_i, bus_size_i};
      assign data_ok    = 1'b1;
    end
  endgenerate

  assign bus_hit = en_i && !pc_src_i && bus_valid_i && bus_addr_ok && dir_ok && asid_ok && data_ok;
  assign pc_hit  = en_i && pc_src_i && exec_valid_i && pc_ok && asid_ok;

  // before-execution, not in a slot: report now; otherwise hold for the next instruction
  assign pc_now     = pc_hit && !after_i && !exec_slot_i;
  assign defer_set  = pc_hit && (after_i || exec_slot_i);
  assign defer_fire = defer_q && exec_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         defer_q <= 1'b0;
    else if (clr_i)      defer_q <= 1'b0;
    else if (defer_set)  defer_q <= 1'b1;
    else if (defer_fire) defer_q <= 1'b0;
  end

  assign ev_o = en_i && !clr_i && (bus_hit || pc_now || defer_fire);

  // R8
  slot_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hit && exec_slot_i && !clr_i) |=> defer_q);

  // R7
  defer_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (defer_q && exec_valid_i && en_i && !clr_i) |-> ev_o);

  // R2
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !ev_o);

  // R12
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !defer_q);
endmodule

// File: rtl/brk_seq.sv
module brk_seq #(
  parameter int NCH = 4,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [SW-1:0]  mode_i,
  input  logic [NCH-1:0] ev_i,
  output logic           brk_o
);
  logic [SW-1:0] stage_q, stage_d, exp_idx;
  logic          chained, in_range, hit_exp, last;

  assign chained  = mode_i != '0;
  assign in_range = stage_q <= mode_i;
  // chain head is channel index mode_i, walks down to index 0
  assign exp_idx  = mode_i - stage_q;
  assign hit_exp  = in_range && ev_i[exp_idx];
  assign last     = stage_q == mode_i;

  always_comb begin
    stage_d = stage_q;
    if (clr_i || !chained || !in_range) stage_d = '0;
    else if (hit_exp)                   stage_d = last ? '0 : stage_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign brk_o = !clr_i && (chained ? (hit_exp && last) : (|ev_i));

  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> (stage_q == '0));

  // R12
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !brk_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chained && !clr_i && in_range && !ev_i[exp_idx]) |=> $stable(stage_q));

  // R9
  chain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chained && brk_o) |-> (stage_q == mode_i && ev_i[0]));
endmodule

// File: rtl/seq_break_unit.sv
module seq_break_unit #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int ASW = 8,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [SW-1:0]      seq_mode_i,
  input  logic [NCH-1:0]     ch_en_i,
  input  logic [NCH-1:0]     ch_pc_i,
  input  logic [NCH-1:0]     ch_after_i,
  input  logic [NCH*AW-1:0]  ch_addr_i,
  input  logic [NCH*AW-1:0]  ch_mask_i,
  input  logic [2*NCH-1:0]   ch_dir_i,
  input  logic [NCH-1:0]     ch_asid_en_i,
  input  logic [NCH*ASW-1:0] ch_asid_i,
  input  logic               dat_en_i,
  input  logic [DW-1:0]      dat_val_i,
  input  logic [1:0]         dat_size_i,
  input  logic               bus_valid_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_data_i,
  input  logic [1:0]         bus_size_i,
  input  logic [ASW-1:0]     asid_i,
  input  logic               exec_valid_i,
  input  logic               exec_slot_i,
  input  logic [AW-1:0]      pc_i,
  output logic               brk_o
);
  logic [NCH-1:0] ev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    brk_chan #(.AW(AW), .DW(DW), .ASW(ASW), .HAS_DATA(i == 0)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (cfg_wr_i),
      .en_i         (ch_en_i[i]),
      .pc_src_i     (ch_pc_i[i]),
      .after_i      (ch_after_i[i]),
      .addr_i       (ch_addr_i[i*AW +: AW]),
      .mask_i       (ch_mask_i[i*AW +: AW]),
      .dir_i        (ch_dir_i[2*i +: 2]),
      .asid_en_i    (ch_asid_en_i[i]),
      .asid_cfg_i   (ch_asid_i[i*ASW +: ASW]),
      .dat_en_i     (dat_en_i),
      .dat_val_i    (dat_val_i),
      .dat_size_i   (dat_size_i),
      .bus_valid_i  (bus_valid_i),
      .bus_wr_i     (bus_wr_i),
      .bus_addr_i   (bus_addr_i),
      .bus_data_i   (bus_data_i),
      .bus_size_i   (bus_size_i),
      .asid_i       (asid_i),
      .exec_valid_i (exec_valid_i),
      .exec_slot_i  (exec_slot_i),
      .pc_i         (pc_i),
      .ev_o         (ev[i])
    );
  end

  brk_seq #(.NCH(NCH)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_wr_i),
    .mode_i (seq_mode_i),
    .ev_i   (ev),
    .brk_o  (brk_o)
  );

  // R1
  indep_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_mode_i == '0 && !cfg_wr_i && |ev) |-> brk_o);
endmodule

// File: tb/seq_break_unit_test.sv
module seq_break_unit_test;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int ASW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_wr, dat_en, bus_valid, bus_wr, exec_valid, exec_slot, brk;
  logic [1:0]        mode, dat_size, bus_size;
  logic [3:0]        c_en, c_pc, c_after, c_asen;
  logic [AW-1:0]     c_addr [4];
  logic [AW-1:0]     c_mask [4];
  logic [1:0]        c_dir  [4];
  logic [ASW-1:0]    c_asid [4];
  logic [DW-1:0]     dat_val, bus_data;
  logic [AW-1:0]     bus_addr, pc;
  logic [ASW-1:0]    asid;
  logic [NCH*AW-1:0]  f_addr, f_mask;
  logic [2*NCH-1:0]   f_dir;
  logic [NCH*ASW-1:0] f_asid;

  always_comb
    for (int i = 0; i < 4; i++) begin
      f_addr[i*AW +: AW]   = c_addr[i];
      f_mask[i*AW +: AW]   = c_mask[i];
      f_dir[2*i +: 2]      = c_dir[i];
      f_asid[i*ASW +: ASW] = c_asid[i];
    end

  seq_break_unit #(.NCH(NCH), .AW(AW), .DW(DW), .ASW(ASW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .seq_mode_i(mode),
    .ch_en_i(c_en), .ch_pc_i(c_pc), .ch_after_i(c_after), .ch_addr_i(f_addr),
    .ch_mask_i(f_mask), .ch_dir_i(f_dir), .ch_asid_en_i(c_asen), .ch_asid_i(f_asid),
    .dat_en_i(dat_en), .dat_val_i(dat_val), .dat_size_i(dat_size),
    .bus_valid_i(bus_valid), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .bus_size_i(bus_size), .asid_i(asid),
    .exec_valid_i(exec_valid), .exec_slot_i(exec_slot), .pc_i(pc), .brk_o(brk)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [3:0] m_defer = '0;
  logic [1:0] m_stage = '0;
  logic [3:0] m_ev, m_set, m_fire;
  logic       m_exp;

  function automatic void m_eval();
    for (int i = 0; i < 4; i++) begin
      logic aok, dok, rok, bh, ph;
      logic [DW-1:0] dm;
      aok = !c_asen[i] || (asid == c_asid[i]);
      dok = (c_dir[i] == 2'd1) ? !bus_wr : (c_dir[i] == 2'd2) ? bus_wr : 1'b1;
      dm  = (dat_size == 2'd0) ? 32'hFF : (dat_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      rok = (i != 0) || !dat_en ||
            (bus_size == dat_size && (bus_data & dm) == (dat_val & dm));
      bh  = !c_pc[i] && bus_valid && ((bus_addr & c_mask[i]) == (c_addr[i] & c_mask[i]))
            && dok && aok && rok;
      ph  = c_pc[i] && exec_valid && ((pc & c_mask[i]) == (c_addr[i] & c_mask[i])) && aok;
      m_set[i]  = c_en[i] && ph && (c_after[i] || exec_slot);
      m_fire[i] = m_defer[i] && exec_valid;
      m_ev[i]   = c_en[i] && !cfg_wr &&
                  (bh || (ph && !c_after[i] && !exec_slot) || m_fire[i]);
    end
    if (cfg_wr)               m_exp = 1'b0;
    else if (mode == 2'd0)    m_exp = |m_ev;
    else if (m_stage > mode)  m_exp = 1'b0;
    else                      m_exp = m_ev[mode - m_stage] && (m_stage == mode);
  endfunction

  function automatic void m_update();
    for (int i = 0; i < 4; i++) begin
      if (cfg_wr)         m_defer[i] = 1'b0;
      else if (m_set[i])  m_defer[i] = 1'b1;
      else if (m_fire[i]) m_defer[i] = 1'b0;
    end
    if (cfg_wr || mode == 2'd0 || m_stage > mode) m_stage = 2'd0;
    else if (m_ev[mode - m_stage]) m_stage = (m_stage == mode) ? 2'd0 : m_stage + 2'd1;
  endfunction

  // one cycle: sample before the edge, compare, then advance the model
  task automatic step(input bit use_exp, input logic exp_v, input string tag);
    logic e;
    @(negedge clk);
    #1;
    m_eval();
    e = use_exp ? exp_v : m_exp;
    n_chk++;
    if (brk !== e) begin
      n_bad++;
      $display("FAIL %s: brk_o=%0b expected %0b at %0t", tag, brk, e, $time);
    end
    @(posedge clk);
    m_update();
    #1;
  endtask

  task automatic idle_in();
    cfg_wr = 0; bus_valid = 0; bus_wr = 0; bus_addr = '0; bus_data = '0; bus_size = 2'd2;
    asid = 8'd1; exec_valid = 0; exec_slot = 0; pc = '0;
  endtask

  task automatic base_cfg(input logic [1:0] md);
    mode = md; c_en = '0; c_pc = '0; c_after = '0; c_asen = '0;
    dat_en = 0; dat_val = '0; dat_size = 2'd2;
    for (int i = 0; i < 4; i++) begin
      c_addr[i] = 32'h100 * (i + 1); c_mask[i] = '1; c_dir[i] = 2'd0; c_asid[i] = 8'd1;
    end
    idle_in();
    cfg_wr = 1;
    step(1, 1'b0, "R12 reconfigure");
    cfg_wr = 0;
  endtask

  task automatic bus(input logic [31:0] a, input logic ex, input string tag);
    idle_in(); bus_valid = 1; bus_addr = a;
    step(1, ex, tag);
  endtask

  task automatic ex_pc(input logic [31:0] a, input logic sl, input logic ex, input string tag);
    idle_in(); exec_valid = 1; pc = a; exec_slot = sl;
    step(1, ex, tag);
  endtask

  function automatic logic [31:0] pick_addr();
    unique case ($urandom_range(0, 5))
      0: return 32'h100; 1: return 32'h200; 2: return 32'h300;
      3: return 32'h400; 4: return 32'h104; default: return 32'h900;
    endcase
  endfunction

  function automatic logic [31:0] pick_data();
    unique case ($urandom_range(0, 3))
      0: return 32'h1234_5678; 1: return 32'h0000_0078;
      2: return 32'hFFFF_5678; default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_in();
    mode = 0; c_en = '0; c_pc = '0; c_after = '0; c_asen = '0;
    dat_en = 0; dat_val = '0; dat_size = 2'd2;
    for (int i = 0; i < 4; i++) begin
      c_addr[i] = '0; c_mask[i] = '1; c_dir[i] = '0; c_asid[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(1, 1'b0, "R1 reset quiet");

    // R1 / R2
    base_cfg(2'd0); c_en[2] = 1;
    bus(32'h300, 1, "R1 independent hit ch3");
    c_en[2] = 0;
    bus(32'h300, 0, "R2 disabled ch3");

    // R3
    base_cfg(2'd0); c_en[0] = 1; c_pc[0] = 1;
    bus(32'h100, 0, "R3 pc channel ignores bus");
    ex_pc(32'h100, 0, 1, "R3 pc match");
    c_mask[0] = 32'hFFFF_FFF0;
    ex_pc(32'h10C, 0, 1, "R3 masked pc match");
    ex_pc(32'h110, 0, 0, "R3 masked pc miss");

    // R4
    base_cfg(2'd0); c_en[1] = 1; c_dir[1] = 2'd2;
    idle_in(); bus_valid = 1; bus_addr = 32'h200; bus_wr = 0; step(1, 0, "R4 write-only vs read");
    idle_in(); bus_valid = 1; bus_addr = 32'h200; bus_wr = 1; step(1, 1, "R4 write-only vs write");
    c_dir[1] = 2'd1;
    idle_in(); bus_valid = 1; bus_addr = 32'h200; bus_wr = 1; step(1, 0, "R4 read-only vs write");

    // R5
    base_cfg(2'd0); c_en[3] = 1; c_asen[3] = 1; c_asid[3] = 8'd5;
    idle_in(); bus_valid = 1; bus_addr = 32'h400; asid = 8'd6; step(1, 0, "R5 asid mismatch");
    idle_in(); bus_valid = 1; bus_addr = 32'h400; asid = 8'd5; step(1, 1, "R5 asid match");

    // R6
    base_cfg(2'd0); c_en[0] = 1; dat_en = 1; dat_val = 32'h1234_5678; dat_size = 2'd0;
    idle_in(); bus_valid = 1; bus_addr = 32'h100; bus_data = 32'hAAAA_AA78; bus_size = 2'd0;
    step(1, 1, "R6 byte data match");
    bus_size = 2'd1; step(1, 0, "R6 size mismatch");
    dat_size = 2'd1; bus_data = 32'h9999_5678; step(1, 1, "R6 word data match");
    bus_data = 32'h9999_5679; step(1, 0, "R6 word data miss");
    c_en[0] = 0; c_en[1] = 1; bus_addr = 32'h200;
    step(1, 1, "R6 ch2 ignores data");

    // R7
    base_cfg(2'd0); c_en[0] = 1; c_pc[0] = 1; c_after[0] = 1;
    ex_pc(32'h100, 0, 0, "R7 after: no report in match cycle");
    idle_in(); step(1, 0, "R7 after: idle cycle");
    ex_pc(32'h500, 0, 1, "R7 after: next instruction");
    ex_pc(32'h504, 0, 0, "R7 after: single report");

    // R8
    base_cfg(2'd0); c_en[0] = 1; c_pc[0] = 1;
    ex_pc(32'h100, 1, 0, "R8 slot match held");
    ex_pc(32'h900, 0, 1, "R8 stops at branch target");
    ex_pc(32'h100, 0, 1, "R8 non-slot stops before");

    // R9 / R11
    base_cfg(2'd1); c_en = 4'b1111;
    bus(32'h100, 0, "R9 ch1 first ignored");
    bus(32'h200, 0, "R9 ch2 arms");
    bus(32'h100, 1, "R9 2->1 break");
    bus(32'h100, 0, "R11 chain restarted");
    bus(32'h400, 0, "R9 ch4 outside chain");

    // R10
    base_cfg(2'd3); c_en = 4'b1111;
    bus(32'h400, 0, "R10 ch4");
    bus(32'h300, 0, "R10 ch3");
    bus(32'h100, 0, "R10 out of order ch1");
    bus(32'h300, 0, "R10 out of order ch3");
    bus(32'h200, 0, "R10 ch2");
    bus(32'h100, 1, "R10 4->3->2->1 break");
    base_cfg(2'd2); c_en = 4'b1111;
    bus(32'h300, 0, "R9 ch3");
    bus(32'h200, 0, "R9 ch2");
    bus(32'h100, 1, "R9 3->2->1 break");

    // R12: strobe together with the completing match
    base_cfg(2'd1); c_en = 4'b0011;
    bus(32'h200, 0, "R12 arm");
    idle_in(); bus_valid = 1; bus_addr = 32'h100; cfg_wr = 1;
    step(1, 0, "R12 strobe suppresses break");
    bus(32'h100, 0, "R12 chain restarted");
    bus(32'h200, 0, "R12 rearm");
    bus(32'h100, 1, "R12 break after rearm");
    base_cfg(2'd0); c_en[0] = 1; c_pc[0] = 1; c_after[0] = 1;
    ex_pc(32'h100, 0, 0, "R12 defer set");
    idle_in(); cfg_wr = 1; step(1, 0, "R12 strobe");
    ex_pc(32'h600, 0, 0, "R12 deferred report dropped");

    // random mix, checked against the model
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        mode = 2'($urandom_range(0, 3));
        c_en = 4'($urandom); c_pc = 4'($urandom); c_after = 4'($urandom); c_asen = 4'($urandom);
        for (int i = 0; i < 4; i++) begin
          c_addr[i] = pick_addr();
          c_mask[i] = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFF0;
          c_dir[i]  = 2'($urandom);
          c_asid[i] = 8'($urandom_range(1, 2));
        end
        dat_en = 1'($urandom); dat_val = pick_data(); dat_size = 2'($urandom_range(0, 2));
        idle_in(); cfg_wr = 1;
      end else begin
        cfg_wr     = ($urandom_range(0, 49) == 0);
        bus_valid  = 1'($urandom); bus_wr = 1'($urandom); bus_addr = pick_addr();
        bus_data   = pick_data(); bus_size = 2'($urandom_range(0, 2));
        asid       = 8'($urandom_range(1, 2));
        exec_valid = 1'($urandom); exec_slot = ($urandom_range(0, 3) == 0); pc = pick_addr();
      end
      step(0, 1'b0, "R1-model random (R9 R10 R11 R12)");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule